// File: doc/BRIEF.md
# Delayed Branch Unit With Annul

This block holds the program counter of an in-order core whose branches take effect one instruction late. Two registers hold the address of the instruction now executing and the address of the one after it. On every accepted instruction the second register moves into the first. A taken branch loads its computed target into the second register, so the instruction that follows the branch (the delay slot) still executes before control moves to the target.

Each branch carries a 4-bit condition code, an annul bit and a signed word displacement. The block evaluates the condition against the four integer flags and computes the target as the branch's own address plus the displacement times four. It also decides whether the delay-slot instruction must be cancelled. With annul clear, the slot always completes. With annul set, the slot is cancelled when the branch is not taken, and also when the condition is the unconditional "always" code. A cancelled instruction is flagged on `squash_o` while it sits at the current address. Its branch fields have no effect.

Instructions arrive as a one-way valid stream: `ins_valid` high means the instruction at `pc_o` executes in this cycle. The unit never stalls, so it has no ready output and the sender sees no back-pressure. The flags and the branch fields are plain inputs, sampled only with `ins_valid`.

Top module: `dbu_branch_unit`

## Requirements
- R1: After reset, `pc_o` equals RESET_PC, `npc_o` equals RESET_PC+4 and `squash_o` is 0.
- R2: On each cycle with `ins_valid` high, `pc_o` takes the previous `npc_o`. For an instruction that is not a live branch, `npc_o` becomes the previous `npc_o`+4. With `ins_valid` low, all three registers hold.
- R3: Condition codes, with flags packed as `cc_flags`={N,Z,V,C} (bit 3 down to bit 0): 0 never, 1 always, 2 Z, 3 !Z, 4 N^V, 5 !(N^V), 6 Z|(N^V), 7 !(Z|(N^V)), 8 C, 9 !C, 10 C|Z, 11 !(C|Z), 12 N, 13 !N, 14 V, 15 !V.
- R4: When a live branch is taken, `npc_o` becomes the branch address plus the sign-extended `br_disp` shifted left by 2. The target therefore reaches `pc_o` one accepted instruction later, after the delay slot.
- R5: A live branch with `br_annul`=0 never squashes its delay slot.
- R6: A live branch with `br_annul`=1 that is not taken sets `squash_o` for its delay slot.
- R7: With `br_annul`=1, a taken branch on code 1 (always) squashes its slot, and a taken branch on any other code does not.
- R8: An instruction accepted while `squash_o` is 1 acts as a non-branch whatever its branch fields, and `squash_o` returns to 0 after it.
- R9: `taken_o` is 1 exactly when `ins_is_br` is 1, `squash_o` is 0 and the condition holds. It does not depend on `ins_valid`.
- R10: `pc_o` and `npc_o` are always word-aligned (low two bits 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction at pc_o executes this cycle |
| ins_is_br | input | 1 | That instruction is a conditional branch |
| br_cond | input | 4 | Branch condition code (R3) |
| br_annul | input | 1 | Annul bit of the branch |
| br_disp | input | DISP_W | Signed word displacement |
| cc_flags | input | 4 | Integer flags {N,Z,V,C} |
| pc_o | output | XLEN | Address of the current instruction |
| npc_o | output | XLEN | Address of the next instruction |
| squash_o | output | 1 | Current instruction must not commit |
| taken_o | output | 1 | Current branch is live and taken |

## Verification
A wrong next-address register shows up on `pc_o` exactly one accepted instruction after the fault. A wrong target or fall-through value therefore appears as a misplaced delay slot, or one instruction later as a jump to the wrong place. A stale or wrong squash bit shows at once on `squash_o` for the slot instruction. If that squashed slot is itself a branch, the error also shows one instruction later on `npc_o`. The sweep covers every condition code against every flag pattern, with both annul values, and follows each branch with a slot that alternates between a plain instruction and a branch.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  localparam int COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    CC_NEVER = 4'd0,  CC_ALWAYS = 4'd1,
    CC_EQ    = 4'd2,  CC_NE     = 4'd3,
    CC_LT    = 4'd4,  CC_GE     = 4'd5,
    CC_LE    = 4'd6,  CC_GT     = 4'd7,
    CC_LTU   = 4'd8,  CC_GEU    = 4'd9,
    CC_LEU   = 4'd10, CC_GTU    = 4'd11,
    CC_NEG   = 4'd12, CC_POS    = 4'd13,
    CC_VS    = 4'd14, CC_VC     = 4'd15
  } br_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/dbu_cond.sv
module dbu_cond
  import dbu_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  ccr_t              flags,
  output logic              hit
);
  localparam int NBASE = 1 << (COND_W - 1);

  // Even codes select a base test, odd codes its negation (R3)
  logic [NBASE-1:0] base;
  logic             lt_s;

  assign lt_s    = flags.n ^ flags.v;
  assign base[0] = 1'b0;
  assign base[1] = flags.z;
  assign base[2] = lt_s;
  assign base[3] = flags.z | lt_s;
  assign base[4] = flags.c;
  assign base[5] = flags.c | flags.z;
  assign base[6] = flags.n;
  assign base[7] = flags.v;

  assign hit = base[code[COND_W-1:1]] ^ code[0];
endmodule

// File: rtl/dbu_target.sv
module dbu_target #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 22
) (
  input  logic [XLEN-1:0]   br_pc,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   target
);
  localparam int ALIGN = 2;
  localparam int EXT_W = XLEN - DISP_W - ALIGN;

  logic [XLEN-1:0] offset;

  generate
    if (EXT_W > 0) begin : g_ext
      assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, {ALIGN{1'b0}}};
    end else begin : g_trunc
      assign offset = {disp[XLEN-ALIGN-1:0], {ALIGN{1'b0}}};
    end
  endgenerate

  assign target = br_pc + offset;
endmodule

// File: rtl/dbu_pcseq.sv
module dbu_pcseq #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            br_live,
  input  logic            hit,
  input  logic            annul,
  input  logic            uncond,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] npc,
  output logic            squash
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic            take;
  logic            kill_slot;
  logic [XLEN-1:0] seq_npc;

  assign take      = br_live & hit;
  assign kill_slot = br_live & annul & (~hit | uncond);
  assign seq_npc   = npc + STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= RESET_PC;
      npc    <= RESET_PC + STEP;
      squash <= 1'b0;
    end else if (step) begin
      pc     <= npc;
      npc    <= take ? target : seq_npc;
      squash <= kill_slot;
    end
  end

  p_pc_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc[1:0] == 2'b00) && (npc[1:0] == 2'b00));
  p_pc_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pc == $past(npc));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && $stable(npc) && $stable(squash));
  p_seq_npc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !br_live |=> npc == $past(npc) + STEP);
  p_taken_tgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && br_live && hit |=> npc == $past(target));
  p_no_annul_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && br_live && !annul |=> !squash);
  p_annul_nt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step && br_live && annul && !hit |=> squash);
  p_annul_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && br_live && annul && hit |=> squash == $past(uncond));
  p_squash_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step && squash |=> !squash);
endmodule

// File: rtl/dbu_branch_unit.sv
module dbu_branch_unit
  import dbu_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              DISP_W   = 22,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic              ins_is_br,
  input  logic [3:0]        br_cond,
  input  logic              br_annul,
  input  logic [DISP_W-1:0] br_disp,
  input  logic [3:0]        cc_flags,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   npc_o,
  output logic              squash_o,
  output logic              taken_o
);
  logic            hit;
  logic            br_live;
  logic            uncond;
  logic [XLEN-1:0] target;
  ccr_t            flags;

  assign flags   = ccr_t'(cc_flags);
  assign br_live = ins_is_br & ~squash_o;
  assign uncond  = (br_cond == CC_ALWAYS);
  assign taken_o = br_live & hit;

  dbu_cond u_cond (
    .code  (br_cond),
    .flags (flags),
    .hit   (hit)
  );

  dbu_target #(.XLEN(XLEN), .DISP_W(DISP_W)) u_target (
    .br_pc  (pc_o),
    .disp   (br_disp),
    .target (target)
  );

  dbu_pcseq #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (ins_valid),
    .br_live (br_live),
    .hit     (hit),
    .annul   (br_annul),
    .uncond  (uncond),
    .target  (target),
    .pc      (pc_o),
    .npc     (npc_o),
    .squash  (squash_o)
  );

  p_taken_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ins_is_br && !squash_o);
  p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cond == CC_NEVER) |-> !taken_o);
endmodule

// File: tb/dbu_branch_unit_tb.sv
module dbu_branch_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN   = 32;
  localparam int DISP_W = 22;
  localparam logic [XLEN-1:0] RST_PC = 32'h0000_1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ins_valid = 1'b0;
  logic              ins_is_br = 1'b0;
  logic [3:0]        br_cond = 4'd0;
  logic              br_annul = 1'b0;
  logic [DISP_W-1:0] br_disp = '0;
  logic [3:0]        cc_flags = 4'd0;
  logic [XLEN-1:0]   pc_o, npc_o;
  logic              squash_o, taken_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [XLEN-1:0] m_pc, m_npc;
  logic            m_sq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbu_branch_unit #(.XLEN(XLEN), .DISP_W(DISP_W), .RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_is_br(ins_is_br),
    .br_cond(br_cond), .br_annul(br_annul), .br_disp(br_disp),
    .cc_flags(cc_flags), .pc_o(pc_o), .npc_o(npc_o),
    .squash_o(squash_o), .taken_o(taken_o)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Condition table from the requirement, one row per code (R3)
  function automatic logic ref_cond(input logic [3:0] code, input logic [3:0] fl);
    logic n, z, v, c;
    n = fl[3]; z = fl[2]; v = fl[1]; c = fl[0];
    case (code)
      4'd0:  return 1'b0;
      4'd1:  return 1'b1;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return n != v;
      4'd5:  return n == v;
      4'd6:  return z || (n != v);
      4'd7:  return !z && (n == v);
      4'd8:  return c;
      4'd9:  return !c;
      4'd10: return c || z;
      4'd11: return !c && !z;
      4'd12: return n;
      4'd13: return !n;
      4'd14: return v;
      default: return !v;
    endcase
  endfunction

  task automatic do_step(input string tag, input logic br, input logic [3:0] code,
                         input logic [3:0] fl, input logic an, input int d);
    logic live, tk, nsq;
    logic [XLEN-1:0] tgt;
    @(negedge clk);
    ins_valid = 1'b1; ins_is_br = br; br_cond = code; cc_flags = fl;
    br_annul = an; br_disp = DISP_W'(d);
    live = br && !m_sq;
    tk   = live && ref_cond(code, fl);
    nsq  = live && an && (!tk || code == 4'd1);
    tgt  = m_pc + XLEN'(d * 4);
    #1;
    check({tag, " R9 taken"}, XLEN'(taken_o), XLEN'(tk));
    @(posedge clk);
    #1;
    ins_valid = 1'b0;
    m_pc  = m_npc;
    m_npc = tk ? tgt : m_npc + 4;
    m_sq  = nsq;
    check({tag, " R2 pc"}, pc_o, m_pc);
    check({tag, " R4 npc"}, npc_o, m_npc);
    check({tag, " R6 squash"}, XLEN'(squash_o), XLEN'(m_sq));
    check({tag, " R10 align"}, XLEN'(pc_o[1:0]), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_pc = RST_PC; m_npc = RST_PC + 4; m_sq = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pc", pc_o, RST_PC);
    check("R1 reset npc", npc_o, RST_PC + 4);
    check("R1 reset squash", XLEN'(squash_o), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Hold with valid low, branch fields driven (R2)
    @(negedge clk);
    ins_is_br = 1'b1; br_cond = 4'd1; br_disp = DISP_W'(100);
    repeat (3) @(negedge clk);
    check("R2 hold pc", pc_o, m_pc);
    check("R2 hold npc", npc_o, m_npc);

    // Full sweep: every code x every flag pattern x annul
    for (int code = 0; code < 16; code++) begin
      for (int fl = 0; fl < 16; fl++) begin
        for (int an = 0; an < 2; an++) begin
          int d;
          d = code * 37 + fl * 5 + an * 3 - 300;
          do_step("R2 plain", 1'b0, 4'd0, 4'(fl), 1'b0, 0);
          do_step("R3 R5 R7 branch", 1'b1, 4'(code), 4'(fl), an[0], d);
          // Slot: a plain op or an annulled always-branch (R8 when squashed)
          do_step("R8 slot", fl[0], 4'd1, 4'(fl), 1'b1, 7);
          if (m_sq)
            do_step("R8 after", 1'b1, 4'd1, 4'(fl), 1'b0, 9);
        end
      end
    end

    // Branch in a squashed slot with its own annul has no effect (R8)
    do_step("R6 nt annul", 1'b1, 4'd0, 4'd0, 1'b1, 40);
    check("R6 slot squashed", XLEN'(squash_o), 1);
    do_step("R8 dead br", 1'b1, 4'd1, 4'd0, 1'b1, 40);
    check("R8 squash clear", XLEN'(squash_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule